// File: doc/BRIEF.md
# Serial Link Port Register and Interrupt Block

This block holds the register-level control and status logic of a byte-wide serial link port. A processor-side byte bus writes and reads it through a 5-bit address. The address space wraps at 32 locations. The block keeps four registers that have behaviour:

- a control register, with four interrupt-enable bits and a link-disable bit;
- a read-only status register;
- a wire register, which drives two open-drain link lines directly;
- a one-byte transmit buffer.

Every other address acts as plain storage.

The bit-level link engine sits outside the block. It supplies four live conditions: error, activity, transmit idle and receive full. It also gives a one-cycle pulse when it has taken the byte out of the transmit buffer. The block returns three things to the engine: a reset pulse, a load pulse, and the buffered byte. A single level-4 interrupt request is raised while any enabled status condition holds and the link is enabled.

Top module: `link_port_regs`

## Requirements
- R1: After reset every stored register reads 0x00, the status register (address 0x0D) reads 0x01, the interrupt request is low, both lines are high, and neither engine pulse is active.
- R2: The interrupt request is high exactly when link-disable (control bit 6) is clear and at least one of these pairs is set: control bit 3 with status bit 7 (error), control bit 2 with status bit 3 (activity), control bit 1 with status bit 6 (transmit idle), or control bit 0 with status bit 5 (receive full).
- R3: A write to the control register (0x0C) with bit 6 set gives a one-cycle engine reset pulse in the cycle after the write. No other write produces that pulse.
- R4: A write to the transmit register (0x0F) gives a one-cycle load pulse in the next cycle and presents the written byte on the transmit data output. It also clears status bit 0 (transmit buffer free).
- R5: A taken pulse from the engine sets status bit 0 in the next cycle. If a transmit write happens in the same cycle, the write wins and the bit is cleared.
- R6: While link-disable is set, a write to the wire register (0x0E) drives the red line to the inverse of data bit 0 and the white line to the inverse of data bit 1. While the link is enabled, both lines are released high, and wire writes do not move them.
- R7: While the link is disabled, the interrupt request stays low, and the receive-full status bit is captured as 0.
- R8: Writes to any address other than 0x0D are stored and read back unchanged. Writes to 0x0D have no effect. The address wraps modulo 32.
- R9: The status register shows the engine inputs one cycle after they are sampled. Bits 4, 2 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| eng_err | input | 1 | Engine error condition |
| eng_act | input | 1 | Engine link activity |
| eng_tx_idle | input | 1 | Engine transmitter idle |
| eng_rx_full | input | 1 | Engine receive byte ready |
| eng_tx_taken | input | 1 | Engine consumed the transmit byte (pulse) |
| eng_rst | output | 1 | Reset pulse to the link engine |
| tx_load | output | 1 | New transmit byte pulse |
| tx_byte | output | 8 | Buffered transmit byte |
| irq_l4 | output | 1 | Level-4 interrupt request |
| red_line | output | 1 | Red wire level (1 = released) |
| white_line | output | 1 | White wire level (1 = released) |

## Verification
The assertions assume that inputs change only between clock edges and that the taken pulse can arrive at any time, including in the same cycle as a transmit write. The bench drives all inputs at the falling edge. Its random traffic aims half of its writes at the four active addresses, and it sets and clears link-disable at random. Directed cases then cover the collision between a transmit write and a taken pulse, wire writes with the link enabled, and the address wrap.

// File: rtl/link_port_pkg.sv
// Package: address map and status bit positions shared by the link port
// register block and its checker. The bit positions are fixed because
// software and the interrupt logic decode them.
package link_port_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 1 << ADDR_W;

    localparam logic [ADDR_W-1:0] A_CTRL = 5'h0C;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h0D;
    localparam logic [ADDR_W-1:0] A_WIRE = 5'h0E;
    localparam logic [ADDR_W-1:0] A_TXD  = 5'h0F;

    // status bit positions
    localparam int S_TXFREE = 0;
    localparam int S_ACT    = 3;
    localparam int S_RXFULL = 5;
    localparam int S_TXIDLE = 6;
    localparam int S_ERR    = 7;

    // control bit positions
    localparam int C_EN_RX  = 0;
    localparam int C_EN_TXI = 1;
    localparam int C_EN_ACT = 2;
    localparam int C_EN_ERR = 3;
    localparam int C_DIS    = 6;
endpackage

// File: rtl/lp_regfile.sv
// Module: lp_regfile
// Byte storage for every address of the port. Each entry holds the last byte
// written to it. The caller gates out any address that must not be stored.
// Assumes one write per cycle; read is combinational.
module lp_regfile #(
    parameter int AW = 5,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [DW-1:0]      wdata,
    input  logic [AW-1:0]      raddr,
    output logic [DW-1:0]      rdata,
    output logic [DEPTH*DW-1:0] flat
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [DW-1:0] q;
        // entry i: capture write data when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (we && waddr == AW'(i))
                q <= wdata;
        end
        assign flat[i*DW +: DW] = q;
    end

    // read mux
    always_comb rdata = flat[raddr*DW +: DW];
endmodule

// File: rtl/lp_status.sv
// Module: lp_status
// Status register of the port. Samples the engine conditions each cycle and
// keeps the transmit-buffer-free flag. Assumes engine inputs are synchronous.
// Receive-full is not captured while the link is disabled.
module lp_status
    import link_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_dis,
    input  logic              eng_err,
    input  logic              eng_act,
    input  logic              eng_tx_idle,
    input  logic              eng_rx_full,
    input  logic              tx_wr,
    input  logic              tx_taken,
    output logic [DATA_W-1:0] stat
);
    logic err_q, act_q, idle_q, rx_q, free_q;

    // sample engine conditions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            act_q  <= 1'b0;
            idle_q <= 1'b0;
            rx_q   <= 1'b0;
        end else begin
            err_q  <= eng_err;
            act_q  <= eng_act;
            idle_q <= eng_tx_idle;
            rx_q   <= eng_rx_full & ~link_dis;
        end
    end

    // transmit buffer free flag: a write clears it, a taken pulse sets it
    always_ff @(posedge clk) begin
        if (!rst_n)
            free_q <= 1'b1;
        else if (tx_wr)
            free_q <= 1'b0;
        else if (tx_taken)
            free_q <= 1'b1;
    end

    // assemble the status byte
    always_comb begin
        stat           = '0;
        stat[S_ERR]    = err_q;
        stat[S_TXIDLE] = idle_q;
        stat[S_RXFULL] = rx_q;
        stat[S_ACT]    = act_q;
        stat[S_TXFREE] = free_q;
    end
endmodule

// File: rtl/lp_irq.sv
// Module: lp_irq
// Combines enabled status conditions into the single level-4 request.
// Purely combinational; suppressed while the link is disabled.
module lp_irq
    import link_port_pkg::*;
(
    input  logic [DATA_W-1:0] ctrl,
    input  logic [DATA_W-1:0] stat,
    output logic              irq
);
    // OR of the four enable/condition pairs
    always_comb begin
        irq = ~ctrl[C_DIS] &
              ((ctrl[C_EN_ERR] & stat[S_ERR])    |
               (ctrl[C_EN_ACT] & stat[S_ACT])    |
               (ctrl[C_EN_TXI] & stat[S_TXIDLE]) |
               (ctrl[C_EN_RX]  & stat[S_RXFULL]));
    end
endmodule

// File: rtl/lp_wire.sv
// Module: lp_wire
// Direct line drive. Holds the inverted wire-register bits written while the
// link is disabled, and releases both lines high while the link is enabled.
module lp_wire (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_dis,
    input  logic       wire_wr,
    input  logic [1:0] wdata,
    output logic       red,
    output logic       white
);
    logic red_q, white_q;

    // latch line levels on a wire write in disabled mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            red_q   <= 1'b1;
            white_q <= 1'b1;
        end else if (wire_wr && link_dis) begin
            red_q   <= ~wdata[0];
            white_q <= ~wdata[1];
        end
    end

    // release lines when the link owns them
    always_comb begin
        red   = link_dis ? red_q   : 1'b1;
        white = link_dis ? white_q : 1'b1;
    end
endmodule

// File: rtl/link_port_regs.sv
// Module: link_port_regs (top)
// Register block of a byte-wide serial link port: control, status, wire
// and transmit registers plus plain storage, and the level-4 interrupt.
// Assumes a single-master byte bus with one write per cycle. All inputs are
// synchronous to clk.
module link_port_regs
    import link_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              eng_err,
    input  logic              eng_act,
    input  logic              eng_tx_idle,
    input  logic              eng_rx_full,
    input  logic              eng_tx_taken,
    output logic              eng_rst,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_byte,
    output logic              irq_l4,
    output logic              red_line,
    output logic              white_line
);
    logic [NUM_REGS*DATA_W-1:0] flat;
    logic [DATA_W-1:0] store_rd, stat, ctrl;
    logic store_we, tx_wr, wire_wr, ctrl_wr, link_dis, tx_ready;
    logic rst_q, load_q;

    // write decode
    always_comb begin
        store_we = wr_en && (wr_addr != A_STAT);
        tx_wr    = wr_en && (wr_addr == A_TXD);
        wire_wr  = wr_en && (wr_addr == A_WIRE);
        ctrl_wr  = wr_en && (wr_addr == A_CTRL);
    end

    lp_regfile #(.AW(ADDR_W), .DW(DATA_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(store_we), .waddr(wr_addr),
        .wdata(wr_data), .raddr(rd_addr), .rdata(store_rd), .flat(flat)
    );

    // register taps
    always_comb begin
        ctrl     = flat[A_CTRL*DATA_W +: DATA_W];
        tx_byte  = flat[A_TXD*DATA_W +: DATA_W];
        link_dis = ctrl[C_DIS];
        tx_ready = stat[S_TXFREE];
    end

    lp_status u_stat (
        .clk(clk), .rst_n(rst_n), .link_dis(link_dis),
        .eng_err(eng_err), .eng_act(eng_act), .eng_tx_idle(eng_tx_idle),
        .eng_rx_full(eng_rx_full), .tx_wr(tx_wr), .tx_taken(eng_tx_taken),
        .stat(stat)
    );

    lp_irq u_irq (.ctrl(ctrl), .stat(stat), .irq(irq_l4));

    lp_wire u_wire (
        .clk(clk), .rst_n(rst_n), .link_dis(link_dis), .wire_wr(wire_wr),
        .wdata(wr_data[1:0]), .red(red_line), .white(white_line)
    );

    // engine reset and load pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q  <= 1'b0;
            load_q <= 1'b0;
        end else begin
            rst_q  <= ctrl_wr && wr_data[C_DIS];
            load_q <= tx_wr;
        end
    end

    // outputs
    always_comb begin
        eng_rst = rst_q;
        tx_load = load_q;
        rd_data = (rd_addr == A_STAT) ? stat : store_rd;
    end
endmodule

// File: rtl/lp_checker.sv
// Module: lp_checker
// Temporal properties of link_port_regs, attached with bind below.
module lp_checker
    import link_port_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              eng_tx_taken,
    input logic              link_dis,
    input logic              tx_ready,
    input logic              irq_l4,
    input logic              red_line,
    input logic              white_line,
    input logic              eng_rst,
    input logic              tx_load
);
    p_rst_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL && wr_data[C_DIS]) |=> eng_rst);

    p_rst_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_addr == A_CTRL && wr_data[C_DIS])) |=> !eng_rst);

    p_tx_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_TXD) |=> (tx_load && !tx_ready));

    p_tx_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_taken && !(wr_en && wr_addr == A_TXD)) |=> tx_ready);

    p_lines_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !link_dis |-> (red_line && white_line));

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_dis |-> !irq_l4);
endmodule

bind link_port_regs lp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .eng_tx_taken(eng_tx_taken), .link_dis(link_dis),
    .tx_ready(tx_ready), .irq_l4(irq_l4), .red_line(red_line),
    .white_line(white_line), .eng_rst(eng_rst), .tx_load(tx_load)
);

// File: tb/tb_link_port_regs.sv
module tb_link_port_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [4:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic eng_err = 0, eng_act = 0, eng_tx_idle = 0, eng_rx_full = 0, eng_tx_taken = 0;
    logic [7:0] rd_data, tx_byte;
    logic eng_rst, tx_load, irq_l4, red_line, white_line;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // model state
    logic [7:0] m_mem [32];
    logic m_s7, m_s6, m_s5, m_s3, m_free, m_red, m_white, m_rst, m_load;

    always #5 clk = ~clk;

    link_port_regs dut (.*);

    function automatic logic [7:0] m_stat();
        return {m_s7, m_s6, m_s5, 1'b0, m_s3, 2'b00, m_free};
    endfunction

    function automatic logic m_irq();
        logic [7:0] c;
        c = m_mem[12];
        return !c[6] && ((c[3] && m_s7) || (c[2] && m_s3) || (c[1] && m_s6) || (c[0] && m_s5));
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_mem[i] = 8'h00;
        {m_s7, m_s6, m_s5, m_s3} = '0;
        m_free = 1; m_red = 1; m_white = 1; m_rst = 0; m_load = 0;
    endtask

    // one clock: apply inputs, update model, check all outputs at negedge
    task automatic step(input logic we, input logic [4:0] wa, input logic [7:0] wd,
                        input logic [4:0] ra, input logic [3:0] cond, input logic tk);
        logic dis;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        {eng_err, eng_act, eng_tx_idle, eng_rx_full} = cond; eng_tx_taken = tk;
        @(posedge clk);
        dis = m_mem[12][6];
        m_s7 = cond[3]; m_s3 = cond[2]; m_s6 = cond[1]; m_s5 = cond[0] & ~dis;
        if (we && wa == 5'h0F) m_free = 0; else if (tk) m_free = 1;
        if (we && wa == 5'h0E && dis) begin m_red = ~wd[0]; m_white = ~wd[1]; end
        m_rst = we && wa == 5'h0C && wd[6];
        m_load = we && wa == 5'h0F;
        if (we && wa != 5'h0D) m_mem[wa] = wd;
        @(negedge clk);
        chk("R2/R7 irq", {7'b0, irq_l4}, {7'b0, m_irq()});
        chk("R3 eng_rst", {7'b0, eng_rst}, {7'b0, m_rst});
        chk("R4 tx_load", {7'b0, tx_load}, {7'b0, m_load});
        chk("R4 tx_byte", tx_byte, m_mem[15]);
        chk("R6 lines", {6'b0, red_line, white_line},
            m_mem[12][6] ? {6'b0, m_red, m_white} : 8'h03);
        chk("R8/R9 rd_data", rd_data, ra == 5'h0D ? m_stat() : m_mem[ra]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        rd_addr = 5'h0D; #1;
        chk("R1 status", rd_data, 8'h01);
        rd_addr = 5'h0C; #1;
        chk("R1 ctrl", rd_data, 8'h00);
        chk("R1 irq/lines/pulses", {irq_l4, red_line, white_line, eng_rst, tx_load}, 5'b01100);

        // R2 each enable pair
        step(1, 5'h0C, 8'h08, 5'h0D, 4'b1000, 0);
        step(0, 0, 0, 5'h0D, 4'b0000, 0);
        step(1, 5'h0C, 8'h04, 5'h0D, 4'b0100, 0);
        step(1, 5'h0C, 8'h02, 5'h0D, 4'b0010, 0);
        step(1, 5'h0C, 8'h01, 5'h0D, 4'b0001, 0);
        step(1, 5'h0C, 8'h0E, 5'h0D, 4'b0001, 0);  // R2 wrong pair: no irq
        step(0, 0, 0, 5'h0D, 4'b1111, 0);
        // R7 disable: irq low, rx_full read 0; R3 pulse
        step(1, 5'h0C, 8'h4F, 5'h0D, 4'b1111, 0);
        step(0, 0, 0, 5'h0D, 4'b1111, 0);
        // R6 wire drive in disabled mode
        step(1, 5'h0E, 8'h01, 5'h0E, 4'b0000, 0);
        step(1, 5'h0E, 8'h02, 5'h0E, 4'b0000, 0);
        // R6 wire write with link enabled: lines stay high
        step(1, 5'h0C, 8'h00, 5'h0C, 4'b0000, 0);
        step(1, 5'h0E, 8'h03, 5'h0E, 4'b0000, 0);
        // R4/R5 tx write, taken, collision
        step(1, 5'h0F, 8'hA5, 5'h0D, 4'b0000, 0);
        step(0, 0, 0, 5'h0D, 4'b0000, 1);
        step(1, 5'h0F, 8'h3C, 5'h0D, 4'b0000, 1);
        step(0, 0, 0, 5'h0D, 4'b0000, 0);
        // R8 status write ignored, storage at other addresses
        step(1, 5'h0D, 8'hFF, 5'h0D, 4'b0000, 0);
        step(1, 5'h1F, 8'h5A, 5'h1F, 4'b0000, 0);
        step(1, 5'h00, 8'hC3, 5'h00, 4'b0000, 0);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] a;
            a = ($urandom % 2) ? 5'(12 + $urandom % 4) : 5'($urandom);
            step($urandom % 2, a, 8'($urandom), 5'($urandom % 3 == 0 ? 13 : $urandom),
                 4'($urandom), ($urandom % 4) == 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule